// File: doc/BRIEF.md
# Sensorless Inductor Current Estimator

This block gives a boost power stage an inductor current value without any current sensor. Each system clock it adds a volt-second term to a running total. While the switch is driven on, the term follows the input voltage. While the switch is off, the term follows the input voltage minus the output voltage. The controller that drives the switch knows the drive state, so the drive level is fed straight in. The total is the estimated inductor current, and a pulse-width controller can compare it against its carrier.

The voltage samples come from slow converters, so each input sample is already old by the time it is registered. To cancel that delay, the input voltage used each clock is projected forward. The projection starts from the newest sample and adds a share of the last sample-to-sample change, one share per clock. A fresh sample restarts the projection. A runtime right shift models the inductance and the unit scaling. The total stays between zero and its positive maximum, so light-load operation with a zero-current interval behaves correctly.

Top module: `isense_rebuild`

## Requirements
- R1: While `rst_n` is low, `i_est` is 0. The stored samples, the sample-to-sample difference and the step counter are also cleared.
- R2: With `sw_on` high, each rising edge adds the term `floor(vop / 2^gain_shift)` to `i_est`, where `vop` is the projected input voltage held before that edge.
- R3: With `sw_on` low, each rising edge adds `floor((vop - vo) / 2^gain_shift)` to `i_est`, where `vo` is the held output sample. This term is normally negative.
- R4: `vop = base + floor(k * diff / NCLK)`. Here `base` is the newest input sample, `diff` is the newest sample minus the one before it, and `k` is the number of clocks since `base` was taken (0 in the cycle right after the strobe edge).
- R5: The step count `k` stops at `NCLK`. If no new sample arrives, `vop` then stays at `base + diff`.
- R6: An edge with `vin_valid` high loads `vin_smp` as the new `base`, forms the new `diff` against the old `base`, and sets `k` to 0. In the next cycle `vop` equals the sample.
- R7: The first input sample after reset gives `diff = 0`, so `vop` stays flat at that sample.
- R8: `i_est` never goes below zero. A sum that would be negative is set to 0.
- R9: `i_est` never goes above `2^(AW-1)-1`. A larger sum is held at that maximum and does not wrap.
- R10: `gain_shift` is an arithmetic right shift (a floor division by a power of two) applied to the signed term. It is applied again on every clock.
- R11: `vo_smp` is taken only on an edge with `vo_valid` high. At all other times, changes on `vo_smp` have no effect on `i_est`.
- R12: `vop` is limited to the range 0 to `2^VW-1` before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; sets the update rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_smp | input | VW | Unsigned input-voltage sample |
| vin_valid | input | 1 | Strobe that marks a new input-voltage sample |
| vo_smp | input | VW | Unsigned output-voltage sample |
| vo_valid | input | 1 | Strobe that marks a new output-voltage sample |
| sw_on | input | 1 | Switch drive state (1 = on) |
| gain_shift | input | SHW | Right-shift amount that models the inductance |
| i_est | output | AW | Signed estimated inductor current |

## Verification
The drive state and gain shift present before a rising edge show up in `i_est` right after that edge. A sample strobe first changes the projected voltage one edge later, so it reaches `i_est` two edges after the strobe. The projection then moves by one step on each following edge. The bench drives inputs on the falling edge and keeps a cycle model built from the requirement formulas. The model is advanced at each rising edge, and `i_est` is compared at the next falling edge, so every check falls in the cycle where the result is due. The sweeps cover every gain shift under both drive states, rising and falling sample pairs (including negative differences that need floor rounding), operand limiting at both ends, and accumulator limiting at zero and at the maximum.

// File: rtl/isr_pkg.sv
package isr_pkg;

    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_e;

    // true when n is a positive power of two
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/isr_extrap.sv
// Projects the input voltage forward between samples.
module isr_extrap #(
    parameter int VW   = 10,
    parameter int NCLK = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] smp,
    input  logic          smp_valid,
    output logic [VW-1:0] vop
);
    localparam int KW = $clog2(NCLK + 1);
    localparam int PW = VW + KW + 2;
    localparam logic [KW-1:0] KMAX = KW'(NCLK);
    localparam logic signed [PW:0] VMAX = (PW + 1)'((2 ** VW) - 1);

    typedef struct packed {
        logic [VW-1:0]      base;
        logic signed [VW:0] diff;
        logic [KW-1:0]      k;
        logic               primed;
    } ext_st_t;

    ext_st_t st_d, st_q;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;
    logic signed [PW:0]   sum;

    // k * diff, both widened with their sign
    always_comb begin
        prod = PW'(st_q.diff) * PW'($signed({1'b0, st_q.k}));
    end

    // floor division by NCLK, picked by the parameter
    generate
        if (isr_pkg::is_pow2(NCLK)) begin : g_div_shift
            localparam int L = $clog2(NCLK);
            always_comb begin
                quot = prod >>> L;
            end
        end else begin : g_div_full
            localparam logic signed [PW-1:0] NDIV = PW'(NCLK);
            logic signed [PW-1:0] qt;
            always_comb begin
                qt   = prod / NDIV;
                quot = qt;
                if ((prod < 0) && ((qt * NDIV) != prod)) begin
                    quot = qt - 1'sb1;
                end
            end
        end
    endgenerate

    // base plus projection, limited to the sample range
    always_comb begin
        sum = (PW + 1)'(quot) + (PW + 1)'($signed({1'b0, st_q.base}));
        if (sum < 0) begin
            vop = '0;
        end else if (sum > VMAX) begin
            vop = {VW{1'b1}};
        end else begin
            vop = sum[VW-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        if (smp_valid) begin
            st_d.base   = smp;
            st_d.diff   = st_q.primed
                        ? ($signed({1'b0, smp}) - $signed({1'b0, st_q.base}))
                        : '0;
            st_d.k      = '0;
            st_d.primed = 1'b1;
        end else if (st_q.k < KMAX) begin
            st_d.k = st_q.k + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/isr_integrator.sv
// Volt-second accumulator with floor at zero and positive saturation.
module isr_integrator #(
    parameter int VW  = 10,
    parameter int AW  = 16,
    parameter int SHW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_on,
    input  logic [VW-1:0]        vop,
    input  logic [VW-1:0]        vo,
    input  logic [SHW-1:0]       gain_shift,
    output logic signed [AW-1:0] acc
);
    import isr_pkg::*;

    localparam int SW = AW + 2;
    localparam logic signed [SW-1:0] AMAX = {3'b000, {(AW - 1){1'b1}}};

    typedef struct packed {
        logic signed [AW-1:0] acc;
    } int_st_t;

    int_st_t st_d, st_q;

    drv_e                 drv;
    logic signed [VW:0]   volt;
    logic signed [VW:0]   term;
    logic signed [SW-1:0] sum;

    // operand and sign follow the drive state
    always_comb begin
        drv = drv_e'(sw_on);
        case (drv)
            DRV_ON:  volt = $signed({1'b0, vop});
            default: volt = $signed({1'b0, vop}) - $signed({1'b0, vo});
        endcase
        term = volt >>> gain_shift;
    end

    always_comb begin
        st_d = st_q;
        sum  = SW'(st_q.acc) + SW'(term);
        if (sum < 0) begin
            st_d.acc = '0;
        end else if (sum > AMAX) begin
            st_d.acc = AMAX[AW-1:0];
        end else begin
            st_d.acc = sum[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

endmodule

// File: rtl/isense_rebuild.sv
// Sensorless inductor current estimator, top level.
module isense_rebuild #(
    parameter int VW   = 10,
    parameter int AW   = 16,
    parameter int SHW  = 3,
    parameter int NCLK = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VW-1:0]        vin_smp,
    input  logic                 vin_valid,
    input  logic [VW-1:0]        vo_smp,
    input  logic                 vo_valid,
    input  logic                 sw_on,
    input  logic [SHW-1:0]       gain_shift,
    output logic signed [AW-1:0] i_est
);
    typedef struct packed {
        logic [VW-1:0] vo;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [VW-1:0] vin_op;
    logic [VW-1:0] vo_q;

    // output-voltage sample holder
    always_comb begin
        st_d = st_q;
        if (vo_valid) begin
            st_d.vo = vo_smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vo_q = st_q.vo;

    isr_extrap #(
        .VW   (VW),
        .NCLK (NCLK)
    ) u_extrap (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp       (vin_smp),
        .smp_valid (vin_valid),
        .vop       (vin_op)
    );

    isr_integrator #(
        .VW  (VW),
        .AW  (AW),
        .SHW (SHW)
    ) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_on      (sw_on),
        .vop        (vin_op),
        .vo         (vo_q),
        .gain_shift (gain_shift),
        .acc        (i_est)
    );

endmodule

// File: rtl/isense_rebuild_chk.sv
module isense_rebuild_chk #(
    parameter int VW  = 10,
    parameter int AW  = 16,
    parameter int SHW = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sw_on,
    input logic                 vin_valid,
    input logic [VW-1:0]        vin_smp,
    input logic                 vo_valid,
    input logic [SHW-1:0]       gain_shift,
    input logic signed [AW-1:0] i_est,
    input logic [VW-1:0]        vin_op,
    input logic [VW-1:0]        vo_q
);
    localparam int MAXI  = (2 ** (AW - 1)) - 1;
    localparam int VMAXI = (2 ** VW) - 1;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (int'(i_est) == 0));

    assert_on_slope_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_on && gain_shift == '0 && int'(i_est) <= MAXI - VMAXI)
        |=> (int'(i_est) == int'($past(i_est)) + int'($past(vin_op))));

    assert_off_slope_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_on && gain_shift == '0 && int'(i_est) >= VMAXI
         && int'(i_est) <= MAXI - VMAXI)
        |=> (int'(i_est) == int'($past(i_est)) + int'($past(vin_op))
                            - int'($past(vo_q))));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vin_valid |=> (vin_op == $past(vin_smp)));

    assert_no_negative_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !i_est[AW-1]);

    assert_hold_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_on && int'(i_est) == MAXI) |=> (int'(i_est) == MAXI));

    assert_vo_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vo_valid |=> $stable(vo_q));

endmodule

bind isense_rebuild isense_rebuild_chk #(
    .VW  (VW),
    .AW  (AW),
    .SHW (SHW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_on      (sw_on),
    .vin_valid  (vin_valid),
    .vin_smp    (vin_smp),
    .vo_valid   (vo_valid),
    .gain_shift (gain_shift),
    .i_est      (i_est),
    .vin_op     (vin_op),
    .vo_q       (vo_q)
);

// File: tb/isense_rebuild_bench.sv
module isense_rebuild_bench;
    localparam int VW   = 10;
    localparam int AW   = 16;
    localparam int SHW  = 3;
    localparam int NC   = 16;
    localparam int MAXI = (2 ** (AW - 1)) - 1;
    localparam int VMX  = (2 ** VW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [VW-1:0]        vin_smp = '0;
    logic                 vin_valid = 1'b0;
    logic [VW-1:0]        vo_smp = '0;
    logic                 vo_valid = 1'b0;
    logic                 sw_on = 1'b0;
    logic [SHW-1:0]       gain_shift = '0;
    logic signed [AW-1:0] i_est;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state, written from the requirements
    int b_m, d_m, k_m, vo_m, acc_m;
    bit pr_m;
    int cur_vin = 0;
    int cur_vo = 0;

    always #4 clk = ~clk;

    isense_rebuild #(
        .VW (VW), .AW (AW), .SHW (SHW), .NCLK (NC)
    ) u_isense_rebuild (
        .clk        (clk),
        .rst_n      (rst_n),
        .vin_smp    (vin_smp),
        .vin_valid  (vin_valid),
        .vo_smp     (vo_smp),
        .vo_valid   (vo_valid),
        .sw_on      (sw_on),
        .gain_shift (gain_shift),
        .i_est      (i_est)
    );

    function automatic int floor_div(input int num, input int den);
        int q;
        q = num / den;
        if (num < 0 && q * den != num) q = q - 1;
        return q;
    endfunction

    function automatic int model_vop();
        int v;
        v = b_m + floor_div(k_m * d_m, NC);      // R4
        if (v < 0) v = 0;                        // R12
        if (v > VMX) v = VMX;
        return v;
    endfunction

    task automatic model_reset();
        b_m = 0; d_m = 0; k_m = 0; vo_m = 0; acc_m = 0; pr_m = 0;
    endtask

    task automatic check(input string tag);
        total++;
        if (int'(i_est) != acc_m) begin
            bad++;
            $display("FAIL %s: i_est actual=%0d expected=%0d", tag, int'(i_est), acc_m);
        end
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit on, input int sh, input bit vv, input bit ov, input string tag);
        int t;
        sw_on      = on;
        gain_shift = SHW'(sh);
        vin_smp    = VW'(cur_vin);
        vo_smp     = VW'(cur_vo);
        vin_valid  = vv;
        vo_valid   = ov;
        @(posedge clk);
        if (on) t = floor_div(model_vop(), 2 ** sh);
        else    t = floor_div(model_vop() - vo_m, 2 ** sh);
        acc_m = acc_m + t;
        if (acc_m < 0) acc_m = 0;                // R8
        if (acc_m > MAXI) acc_m = MAXI;          // R9
        if (vv) begin
            d_m  = pr_m ? (cur_vin - b_m) : 0;   // R6, R7
            b_m  = cur_vin;
            k_m  = 0;
            pr_m = 1;
        end else if (k_m < NC) begin
            k_m++;                               // R5
        end
        if (ov) vo_m = cur_vo;                   // R11
        @(negedge clk);
        check(tag);
    endtask

    task automatic run(input int n, input bit on, input int sh, input string tag);
        for (int i = 0; i < n; i++) cyc(on, sh, 1'b0, 1'b0, tag);
    endtask

    task automatic smp_vin(input int v, input bit on, input string tag);
        cur_vin = v;
        cyc(on, 0, 1'b1, 1'b0, tag);
    endtask

    task automatic smp_vo(input int v, input bit on, input string tag);
        cur_vo = v;
        cyc(on, 0, 1'b0, 1'b1, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        vin_valid = 1'b0;
        vo_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;

        // no sample yet: operand is zero
        run(4, 1, 0, "R2 idle");
        // first sample: flat projection
        smp_vin(100, 1, "R7 first");
        run(5, 1, 0, "R7 flat");
        run(5, 1, 0, "R2 on");
        for (int sh = 0; sh < 8; sh++) run(3, 1, sh, "R10 on shift");

        // off phase down to the zero floor
        smp_vo(600, 1, "R11 load");
        run(6, 0, 0, "R3 off");
        run(4, 0, 2, "R8 floor");

        // projection with positive then negative difference
        smp_vin(164, 1, "R6 rise");
        run(16, 1, 0, "R4 ramp up");
        run(6, 1, 0, "R5 hold");
        smp_vin(159, 1, "R6 fall");
        run(20, 1, 0, "R4 floor neg");
        run(8, 0, 1, "R3 off proj");

        // operand limits at both ends
        smp_vin(1000, 1, "R6");
        smp_vin(1020, 1, "R6");
        run(20, 1, 1, "R12 top");
        smp_vin(20, 1, "R6");
        run(20, 1, 0, "R12 bottom");
        smp_vin(0, 1, "R6");
        run(20, 1, 0, "R12 zero");

        // saturation at the positive maximum
        smp_vin(1000, 1, "R6");
        smp_vin(1000, 1, "R6");
        run(40, 1, 0, "R9 max");

        // vo_smp changes without strobe
        cur_vo = 100;
        run(6, 0, 0, "R11 ignore");
        smp_vo(1023, 0, "R11 load");
        run(10, 0, 3, "R3 off big");

        // sample restarts across a sequence
        smp_vin(300, 1, "R6"); run(7, 1, 0, "R6 seq");
        smp_vin(280, 1, "R6"); run(7, 1, 0, "R6 seq");
        smp_vin(500, 1, "R6"); run(7, 1, 0, "R6 seq");
        smp_vin(499, 1, "R6"); run(7, 1, 0, "R6 seq");
        smp_vin(777, 1, "R6"); run(7, 1, 0, "R6 seq");

        // sweep drive state x shift x sample pattern
        smp_vo(700, 1, "R11 load");
        for (int on = 0; on < 2; on++) begin
            for (int sh = 0; sh < 8; sh++) begin
                for (int j = 0; j < 4; j++) begin
                    smp_vin((j * 311 + sh * 97 + on * 53) % 1024, on[0], "R6 sweep");
                    run(3, on[0], sh, on[0] ? "R2 sweep" : "R3 sweep");
                    run(2, on[0], sh, "R10 sweep");
                end
            end
        end

        // reset mid-run, then first-sample rule again
        do_reset();
        run(3, 1, 0, "R1 after");
        smp_vin(400, 1, "R7 again");
        run(8, 1, 0, "R7 flat again");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule